// File: doc/BRIEF.md
# Bank-Parallel Burst Request Arbiter

This block picks, every cycle, which of several cores may pass its oldest pending memory request into the shared DRAM request buffers. It does not rotate fairly. It keeps granting one selected core for a run of consecutive requests. A core's requests to different banks therefore reach the DRAM controller close together, and the controller can service them in parallel.

A burst limit caps each run so that a heavy core cannot starve the others. When the limit is reached, or when the selected core runs dry, selection jumps to the pending core with the best rank. Ranks come from per-core tallies of last-level cache misses. The tallies are taken over a fixed interval. A core that missed less gets a higher rank, because delaying a light memory user costs more than delaying a heavy one.

Each core presents a valid flag and its oldest request. The block returns a single output stream with a ready input. It also returns a per-core pop strobe, which tells the owning queue that its head was taken.

Top module: `blp_burst_arbiter`

## Requirements
- R1: `outValid` is high exactly when at least one core has `reqValid` set. `outCore` then names a core whose `reqValid` is high. `outData` equals that core's slice `reqData[outCore*DATA_W +: DATA_W]`. `reqPop` is one-hot on `outCore` in a cycle with `outReady` high, and zero otherwise.
- R2: While the selected core has a pending request and fewer than `SEND_LIMIT` requests have been accepted from it since it was selected, it keeps the grant, even if higher-ranked cores are pending.
- R3: Once `SEND_LIMIT` requests from the selected core have been accepted, the next grant goes to the highest-ranked pending core. This may be the same core. Its consecutive count restarts from zero.
- R4: If the selected core has no pending request, the grant moves to the highest-ranked core that has one.
- R5: Rank order is by ascending miss count in the last completed interval, and equal counts rank the lower core index higher. Before the first interval completes, core 0 ranks highest, then core 1, and so on.
- R6: Ranks change only at an interval boundary, once every `INTERVAL` cycles after reset. Each boundary uses only the misses of the interval that just ended. A miss event in the boundary cycle itself counts toward the new interval.
- R7: The consecutive count advances only on an accepted transfer, meaning `outValid` and `outReady` are both high. While `outReady` is low, nothing is popped and the grant stays on the selected core.
- R8: After reset, `outValid` and `reqPop` are low until a request arrives, core 0 is the selected core, and its consecutive count is zero.
- R9: Each miss tally saturates at its all-ones value (`2**MISS_W-1`) rather than wrapping, so two cores that both exceed it rank by index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CORES | Per-core flag that a request is pending |
| reqData | input | NUM_CORES*DATA_W | Per-core oldest pending request, core i in slice i |
| missEvent | input | NUM_CORES | Per-core last-level cache miss pulse, one miss per cycle high |
| outReady | input | 1 | Downstream buffer can take a request this cycle |
| outValid | output | 1 | A granted request is presented |
| outData | output | DATA_W | The granted core's oldest request |
| outCore | output | CORE_W | Index of the granted core |
| reqPop | output | NUM_CORES | One-hot strobe: head of this core's queue was accepted |

## Verification
The hardest situation to reach is a rank order that differs from index order and is also stable while a drain is observed. With saturation in play, the order must also differ from what a wrapping tally would give. The bench drives a fixed miss pattern on every cycle for more than two full intervals before it loads any requests. Every boundary that can occur during the drain then recomputes the same order. Requests are loaded while `outReady` is low, in two steps, so that the selected core is known when the drain starts. The resulting grant sequence then exposes the whole rank order.

// File: rtl/blp_arb_pkg.sv
package blp_arb_pkg;

  // Strobes from the selection control to the datapath registers.
  typedef struct packed {
    logic anyValid;   // at least one core has a pending request
    logic accept;     // the presented request is taken this cycle
    logic switchNow;  // selection moves to the best-ranked pending core
  } arb_strobe_t;

endpackage

// File: rtl/blp_rank_tracker.sv
module blp_rank_tracker #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int MISS_W    = 16,
  parameter int INTERVAL  = 100000
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CORES-1:0]             missEvent,
  output logic [NUM_CORES-1:0][CORE_W-1:0] rankPos
);

  localparam int TMR_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(INTERVAL - 1);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [TMR_W-1:0]  intervalTmr;
  logic              rankTick;
  logic [MISS_W-1:0] missCnt [NUM_CORES];
  logic [NUM_CORES-1:0][CORE_W-1:0] nextRank;

  assign rankTick = (intervalTmr == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)        intervalTmr <= '0;
    else if (rankTick) intervalTmr <= '0;
    else              intervalTmr <= intervalTmr + TMR_W'(1);
  end

  // Saturating per-core miss tallies, restarted at each boundary.
  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_miss
    always_ff @(posedge clk) begin
      if (!rstN)
        missCnt[gi] <= '0;
      else if (rankTick)
        missCnt[gi] <= MISS_W'(missEvent[gi]);
      else if (missEvent[gi] && (missCnt[gi] != MISS_MAX))
        missCnt[gi] <= missCnt[gi] + MISS_W'(1);
    end
  end

  // Position = number of cores that rank ahead (fewer misses, or equal and lower index).
  always_comb begin
    for (int i = 0; i < NUM_CORES; i++) begin
      nextRank[i] = '0;
      for (int j = 0; j < NUM_CORES; j++) begin
        if ((missCnt[j] < missCnt[i]) || ((missCnt[j] == missCnt[i]) && (j < i)))
          nextRank[i] = nextRank[i] + CORE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CORES; i++) rankPos[i] <= CORE_W'(i);
    end else if (rankTick) begin
      rankPos <= nextRank;
    end
  end

  // Every position from 0 to NUM_CORES-1 is held by exactly one core.
  logic [NUM_CORES-1:0] posHit;
  always_comb begin
    posHit = '0;
    for (int p = 0; p < NUM_CORES; p++)
      for (int i = 0; i < NUM_CORES; i++)
        if (rankPos[i] == CORE_W'(p)) posHit[p] = 1'b1;
  end

  assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rstN)
    &posHit);

  assert_rank_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rankTick |=> $stable(rankPos));

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_chk
    assert_tally_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
      rankTick |=> (missCnt[gi] <= MISS_W'(1)));
  end

endmodule

// File: rtl/blp_arb_control.sv
module blp_arb_control
  import blp_arb_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int CORE_W     = $clog2(NUM_CORES),
  parameter int SEND_LIMIT = 10,
  parameter int CNT_W      = $clog2(SEND_LIMIT + 1)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CORES-1:0]             reqValid,
  input  logic [NUM_CORES-1:0][CORE_W-1:0] rankPos,
  input  logic [CORE_W-1:0]                selCore,
  input  logic [CNT_W-1:0]                 burstCnt,
  input  logic                             outReady,
  output logic [CORE_W-1:0]                grantCore,
  output arb_strobe_t                      strobe
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SEND_LIMIT);

  logic              bestFound;
  logic [CORE_W-1:0] bestIdx;
  logic [CORE_W-1:0] bestPos;
  logic              selPending;
  logic              limitHit;

  // Highest-ranked (smallest position) pending core.
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestPos   = '1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (reqValid[i] && (!bestFound || (rankPos[i] < bestPos))) begin
        bestFound = 1'b1;
        bestIdx   = CORE_W'(i);
        bestPos   = rankPos[i];
      end
    end
  end

  assign selPending = reqValid[selCore];
  assign limitHit   = (burstCnt >= LIMIT);

  always_comb begin
    strobe.anyValid  = bestFound;
    strobe.switchNow = bestFound && (!selPending || limitHit);
    strobe.accept    = bestFound && outReady;
    grantCore        = strobe.switchNow ? bestIdx : selCore;
  end

  assert_grant_pending_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.anyValid |-> reqValid[grantCore]);

  assert_stick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selPending && !limitHit) |-> (grantCore == selCore));

endmodule

// File: rtl/blp_arb_datapath.sv
module blp_arb_datapath
  import blp_arb_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int CORE_W     = $clog2(NUM_CORES),
  parameter int DATA_W     = 64,
  parameter int SEND_LIMIT = 10,
  parameter int CNT_W      = $clog2(SEND_LIMIT + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES*DATA_W-1:0]   reqData,
  input  logic [CORE_W-1:0]             grantCore,
  input  arb_strobe_t                   strobe,
  output logic [CORE_W-1:0]             selCore,
  output logic [CNT_W-1:0]              burstCnt,
  output logic                          outValid,
  output logic [DATA_W-1:0]             outData,
  output logic [NUM_CORES-1:0]          reqPop
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SEND_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selCore  <= '0;
      burstCnt <= '0;
    end else if (strobe.anyValid) begin
      selCore <= grantCore;
      if (strobe.switchNow)
        burstCnt <= strobe.accept ? CNT_W'(1) : '0;
      else if (strobe.accept)
        burstCnt <= burstCnt + CNT_W'(1);
    end
  end

  assign outValid = strobe.anyValid;
  assign outData  = reqData[int'(grantCore)*DATA_W +: DATA_W];

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_pop
    assign reqPop[gi] = strobe.accept && (grantCore == CORE_W'(gi));
  end

  assert_burst_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    burstCnt <= LIMIT);

  assert_pop_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqPop));

  assert_count_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accept |=> ((burstCnt == '0) || (burstCnt == $past(burstCnt))));

  assert_reset_state_R8: assert property (@(posedge clk)
    $past(!rstN) && rstN |-> ((selCore == '0) && (burstCnt == '0)));

endmodule

// File: rtl/blp_burst_arbiter.sv
module blp_burst_arbiter
  import blp_arb_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int CORE_W     = $clog2(NUM_CORES),
  parameter int DATA_W     = 64,
  parameter int MISS_W     = 16,
  parameter int INTERVAL   = 100000,
  parameter int SEND_LIMIT = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [NUM_CORES*DATA_W-1:0] reqData,
  input  logic [NUM_CORES-1:0]        missEvent,
  input  logic                        outReady,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic [CORE_W-1:0]           outCore,
  output logic [NUM_CORES-1:0]        reqPop
);

  localparam int CNT_W = $clog2(SEND_LIMIT + 1);

  logic [NUM_CORES-1:0][CORE_W-1:0] rankPos;
  logic [CORE_W-1:0]                selCore;
  logic [CNT_W-1:0]                 burstCnt;
  logic [CORE_W-1:0]                grantCore;
  arb_strobe_t                      strobe;

  blp_rank_tracker #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .MISS_W(MISS_W), .INTERVAL(INTERVAL)
  ) u_rank (
    .clk(clk), .rstN(rstN), .missEvent(missEvent), .rankPos(rankPos)
  );

  blp_arb_control #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .SEND_LIMIT(SEND_LIMIT), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rankPos(rankPos),
    .selCore(selCore), .burstCnt(burstCnt), .outReady(outReady),
    .grantCore(grantCore), .strobe(strobe)
  );

  blp_arb_datapath #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .DATA_W(DATA_W),
    .SEND_LIMIT(SEND_LIMIT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqData(reqData), .grantCore(grantCore),
    .strobe(strobe), .selCore(selCore), .burstCnt(burstCnt),
    .outValid(outValid), .outData(outData), .reqPop(reqPop)
  );

  assign outCore = grantCore;

  assert_pop_needs_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|reqPop) |-> (outValid && outReady));

endmodule

// File: tb/tb_blp_burst_arbiter.sv
module tb_blp_burst_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int DW = 16;
  localparam int IVL = 40;
  localparam int LIM = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0] reqValid;
  logic [NC*DW-1:0] reqData;
  logic [NC-1:0] missEvent = '0;
  logic outReady = 1'b0;
  logic outValid;
  logic [DW-1:0] outData;
  logic [CW-1:0] outCore;
  logic [NC-1:0] reqPop;

  int unsigned added [NC];
  int unsigned popped [NC];
  int unsigned expSeq [NC];
  int missMode = 0;
  bit missToggle = 1'b0;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [CW-1:0] expCoreQ [$];
  logic [DW-1:0] expDataQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  blp_burst_arbiter #(
    .NUM_CORES(NC), .DATA_W(DW), .MISS_W(4), .INTERVAL(IVL), .SEND_LIMIT(LIM)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData),
    .missEvent(missEvent), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outCore(outCore), .reqPop(reqPop)
  );

  initial for (int i = 0; i < NC; i++) begin added[i] = 0; popped[i] = 0; expSeq[i] = 0; end

  // Upstream queue model: head sequence number is the count already popped.
  always_comb begin
    for (int i = 0; i < NC; i++) begin
      reqValid[i] = (added[i] != popped[i]);
      reqData[i*DW +: DW] = {4'(i), 12'(popped[i])};
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NC; i++) if (reqPop[i]) popped[i] <= popped[i] + 1;
  end

  // Miss pattern generator, one pattern per mode, applied every cycle.
  always begin
    @(posedge clk); #1;
    missToggle = ~missToggle;
    case (missMode)
      1: missEvent = 4'b0011;
      2: missEvent = {2'b00, missToggle, 1'b1};
      3: missEvent = 4'b0101;
      default: missEvent = 4'b0000;
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loadCore(input int c, input int n);
    added[c] = added[c] + n;
  endtask

  task automatic expectGrant(input int c);
    expCoreQ.push_back(CW'(c));
    expDataQ.push_back({4'(c), 12'(expSeq[c])});
    expSeq[c]++;
  endtask

  // Monitor: every accepted transfer is popped from the scoreboard and compared.
  always @(negedge clk) begin
    if (rstN && outValid && outReady && !done) begin
      if (expCoreQ.size() == 0) begin
        check(1'b0, "R1 unexpected transfer", int'(outCore), 0);
      end else begin
        logic [CW-1:0] ec;
        logic [DW-1:0] ed;
        ec = expCoreQ.pop_front();
        ed = expDataQ.pop_front();
        check(outCore == ec, "R2/R3/R4/R5 grant order", int'(outCore), int'(ec));
        check(outData == ed, "R1 granted data", int'(outData), int'(ed));
        check(reqPop == (NC'(1) << ec), "R1 pop strobe", int'(reqPop), int'(NC'(1) << ec));
      end
    end
  end

  task automatic drain(input string req);
    outReady = 1'b1;
    for (int k = 0; k < 60 && expCoreQ.size() != 0; k++) step(1);
    step(2);
    check(expCoreQ.size() == 0, req, expCoreQ.size(), 0);
    outReady = 1'b0;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    @(negedge clk);
    // R8: nothing pending after reset
    check(outValid == 1'b0, "R8 outValid after reset", int'(outValid), 0);
    check(reqPop == '0, "R8 reqPop after reset", int'(reqPop), 0);

    // Phase B: default index ranks; burst limit and dry-core switching.
    step(1);
    loadCore(3, 5);
    step(2);
    @(negedge clk);
    check(outValid == 1'b1, "R1 valid with pending", int'(outValid), 1);
    check(outCore == 2'd3, "R4 move off dry core", int'(outCore), 3);
    check(reqPop == '0, "R7 no pop while not ready", int'(reqPop), 0);
    step(1);
    loadCore(0, 2);
    step(2);
    @(negedge clk);
    check(outCore == 2'd3, "R2 stays despite higher rank", int'(outCore), 3);
    check(reqPop == '0, "R7 stall holds", int'(reqPop), 0);
    step(1);
    expectGrant(3); expectGrant(3); expectGrant(3);
    expectGrant(0); expectGrant(0);
    expectGrant(3); expectGrant(3);
    drain("R3 burst limit sequence complete");

    // Phase C: cores 0,1 miss each cycle; order 2,3,0,1.
    missMode = 1;
    step(2*IVL + 5);
    loadCore(0, 1); loadCore(1, 1); loadCore(2, 1);
    step(2);
    loadCore(3, 1);
    step(1);
    expectGrant(2); expectGrant(3); expectGrant(0); expectGrant(1);
    drain("R5 rank order by misses");

    // Phase D: saturating tallies make cores 0 and 1 tie.
    missMode = 2;
    step(2*IVL + 5);
    loadCore(0, 1); loadCore(2, 1); loadCore(3, 1);
    step(2);
    loadCore(1, 1);
    step(1);
    expectGrant(2); expectGrant(3); expectGrant(0); expectGrant(1);
    drain("R9 saturated tie by index");

    // Phase E: tallies restart each interval; order 1,3,0,2.
    missMode = 3;
    step(2*IVL + 5);
    loadCore(0, 1); loadCore(2, 1); loadCore(3, 1);
    step(2);
    loadCore(1, 1);
    step(1);
    expectGrant(3); expectGrant(1); expectGrant(0); expectGrant(2);
    drain("R6 interval restart of tallies");

    @(negedge clk);
    check(outValid == 1'b0, "R1 idle when nothing pending", int'(outValid), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule